// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the purely combinational arithmetic and logic stage of a 32-bit RISC execute unit. It receives the whole instruction word, the value of the first source register, an operand that an external shifter has already moved into place together with that shifter's carry, the current four condition flags (negative, zero, carry, overflow), and a signal telling whether the current processor mode owns a saved status register. From these it produces the result, a destination write enable, the next flag values, and a request to copy the saved status back into the live status.

The second operand is either the supplied shifted register value or an 8-bit constant taken from the instruction and rotated right by an even amount. Sixteen operations are decoded from a 4-bit field. They fall into three flag classes: additive, subtractive (including reversed forms) and logical. Four of the operations only compare or test and never write a register. When the flag-update bit is set and the destination is register 15 in a mode that owns a saved status, the block raises the restore request in place of computing flags.

Top module: `dp_alu_unit`

## Requirements
- R1: With bit 25 set, the second operand is bits 7:0 zero-extended and rotated right by two times the value of bits 11:8.
- R2: For an immediate operand, the operand carry equals the incoming C flag when bits 11:8 are zero, and bit 31 of the rotated constant otherwise.
- R3: With bit 25 clear, the second operand and its carry are the supplied shifted value and shifted carry.
- R4: Opcodes 4 (add), 5 (add with carry, adds C) and 11 (compare-negative, add without write) set C to the carry out of bit 31 and V to signed overflow.
- R5: Opcodes 2 (first minus second), 3 (second minus first) and 10 (compare, first minus second without write) set C to NOT borrow and V to signed subtraction overflow.
- R6: Opcodes 6 (first minus second) and 7 (second minus first) subtract one more when C is clear.
- R7: Logical opcodes 0 (and), 1 (xor), 8 (and-test), 9 (xor-test), 12 (or), 13 (move second), 14 (first and not second), 15 (not second) take C from the operand carry and keep V.
- R8: Opcodes 8 through 11 never assert the write enable; all other opcodes assert it.
- R9: With the flag-update bit (bit 20) clear, the flags out equal the flags in.
- R10: With bit 20 set, destination field 15 and the saved-status signal high, the restore request is asserted and the flags out equal the flags in; otherwise the request is low.
- R11: On a flag update, N is result bit 31 and Z is set exactly when the result is zero.
- R12: The destination index is bits 15:12 and the first-operand index is bits 19:16; the flags bus is ordered N, Z, C, V from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | First-operand register value |
| shop_val | input | 32 | Pre-shifted register operand |
| shop_carry | input | 1 | Carry produced by the external shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| mode_has_saved | input | 1 | Current mode owns a saved status register |
| result | output | 32 | Operation result |
| rd_idx | output | 4 | Destination register index |
| rn_idx | output | 4 | First-operand register index |
| rd_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| restore_req | output | 1 | Request to restore status from the saved copy |

## Verification
The two functions that meet in one evaluation are flag generation and the status-restore path: an instruction with the update bit set, destination 15 and a mode owning a saved status computes a valid result and also asks for the restore, which must win over the new flags. The sweep places destination 15 and the saved-status signal on several operand patterns for every opcode and class, with the update bit both set and clear, and judges that the flags stay at their incoming value, the request appears only in the full coincidence, and the result and write enable are unaffected.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND   = 4'h0,
      OP_XOR   = 4'h1,
      OP_SUB   = 4'h2,
      OP_RSUB  = 4'h3,
      OP_ADD   = 4'h4,
      OP_ADDC  = 4'h5,
      OP_SUBC  = 4'h6,
      OP_RSUBC = 4'h7,
      OP_TSTA  = 4'h8,
      OP_TSTX  = 4'h9,
      OP_CMPS  = 4'hA,
      OP_CMPA  = 4'hB,
      OP_OR    = 4'hC,
      OP_MOVE  = 4'hD,
      OP_CLRB  = 4'hE,
      OP_NOT   = 4'hF
   } dp_op_e;

   typedef enum logic [1:0] {
      CLS_LOGIC = 2'd0,
      CLS_ADD   = 2'd1,
      CLS_SUB   = 2'd2
   } dp_cls_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } dp_flags_t;

   function automatic dp_cls_e op_class(input dp_op_e op);
      case (op)
         OP_ADD, OP_ADDC, OP_CMPA:                          return CLS_ADD;
         OP_SUB, OP_RSUB, OP_SUBC, OP_RSUBC, OP_CMPS:       return CLS_SUB;
         default:                                           return CLS_LOGIC;
      endcase
   endfunction

endpackage

// File: rtl/dp_imm_rot.sv
module dp_imm_rot #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic [ROT_W-1:0]  rot,
   input  logic              c_in,
   output logic [DATA_W-1:0] value,
   output logic              c_out
);
   localparam int MAX_AMT = 2 * ((1 << ROT_W) - 1);

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("dp_imm_rot: IMM_W exceeds DATA_W");
      end
      if (MAX_AMT >= DATA_W) begin : g_bad_rot
         $error("dp_imm_rot: rotate range exceeds DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0]   ext;
   logic [2*DATA_W-1:0] dbl;
   logic [2*DATA_W-1:0] shifted;
   logic [ROT_W:0]      amt;

   always_comb begin
      ext     = {{(DATA_W-IMM_W){1'b0}}, imm};
      dbl     = {ext, ext};
      amt     = {rot, 1'b0};
      shifted = dbl >> amt;
      value   = shifted[DATA_W-1:0];
      c_out   = (rot == '0) ? c_in : value[DATA_W-1];
   end

   always_comb begin
      if (rot == '0) begin
         // R2
         imm_carry_chk: assert (c_out == c_in && value[DATA_W-1:IMM_W] == '0);
      end
   end

endmodule

// File: rtl/dp_arith_core.sv
module dp_arith_core
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  dp_op_e            op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              c_flag,
   output logic [DATA_W-1:0] res,
   output logic              arith_c,
   output logic              arith_v,
   output logic              wr_en
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] x, y;
   logic              cin;
   logic [DATA_W:0]   sum;
   logic [DATA_W-1:0] logic_res;
   dp_cls_e           cls;

   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      case (op)
         OP_ADD, OP_CMPA: begin x = a; y = b;  cin = 1'b0;   end
         OP_ADDC:         begin x = a; y = b;  cin = c_flag; end
         OP_SUB, OP_CMPS: begin x = a; y = ~b; cin = 1'b1;   end
         OP_SUBC:         begin x = a; y = ~b; cin = c_flag; end
         OP_RSUB:         begin x = b; y = ~a; cin = 1'b1;   end
         OP_RSUBC:        begin x = b; y = ~a; cin = c_flag; end
         default:         begin x = a; y = b;  cin = 1'b0;   end
      endcase
      sum     = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
      arith_c = sum[DATA_W];
      arith_v = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
   end

   always_comb begin
      case (op)
         OP_AND, OP_TSTA: logic_res = a & b;
         OP_XOR, OP_TSTX: logic_res = a ^ b;
         OP_OR:           logic_res = a | b;
         OP_MOVE:         logic_res = b;
         OP_CLRB:         logic_res = a & ~b;
         OP_NOT:          logic_res = ~b;
         default:         logic_res = '0;
      endcase
   end

   always_comb begin
      cls   = op_class(op);
      res   = (cls == CLS_LOGIC) ? logic_res : sum[DATA_W-1:0];
      wr_en = !(op == OP_TSTA || op == OP_TSTX || op == OP_CMPS || op == OP_CMPA);
   end

endmodule

// File: rtl/dp_flag_unit.sv
module dp_flag_unit
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              s_bit,
   input  logic              rd_is_pc,
   input  logic              mode_has_saved,
   input  dp_cls_e           cls,
   input  logic [DATA_W-1:0] res,
   input  logic              arith_c,
   input  logic              arith_v,
   input  logic              opnd_c,
   input  dp_flags_t         f_in,
   output dp_flags_t         f_out,
   output logic              restore
);
   dp_flags_t calc;

   always_comb begin
      calc.n = res[DATA_W-1];
      calc.z = (res == '0);
      if (cls == CLS_LOGIC) begin
         calc.c = opnd_c;
         calc.v = f_in.v;
      end else begin
         calc.c = arith_c;
         calc.v = arith_v;
      end
      restore = s_bit && rd_is_pc && mode_has_saved;
      if (!s_bit || restore) f_out = f_in;
      else                   f_out = calc;
   end

   always_comb begin
      if (!s_bit) begin
         // R9
         hold_flags_chk: assert (f_out == f_in && !restore);
      end
      if (s_bit && !restore && cls == CLS_LOGIC) begin
         // R7
         keep_v_chk: assert (f_out.v == f_in.v && f_out.c == opnd_c);
      end
   end

endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
   import dp_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 8,
   parameter int ROT_W   = 4,
   parameter int REG_W   = 4
) (
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] shop_val,
   input  logic              shop_carry,
   input  logic [3:0]        flags_in,
   input  logic              mode_has_saved,
   output logic [DATA_W-1:0] result,
   output logic [REG_W-1:0]  rd_idx,
   output logic [REG_W-1:0]  rn_idx,
   output logic              rd_we,
   output logic [3:0]        flags_out,
   output logic              restore_req
);
   localparam int IMM_LSB = 0;
   localparam int ROT_LSB = IMM_LSB + IMM_W;
   localparam int RD_LSB  = ROT_LSB + ROT_W;
   localparam int RN_LSB  = RD_LSB + REG_W;
   localparam int S_POS   = RN_LSB + REG_W;
   localparam int OP_LSB  = S_POS + 1;
   localparam int I_POS   = OP_LSB + 4;
   localparam logic [REG_W-1:0] PC_IDX = '1;

   generate
      if (I_POS > 31) begin : g_bad_fields
         $error("dp_alu_unit: instruction fields exceed word");
      end
   endgenerate

   dp_op_e            op;
   logic              s_bit, i_bit;
   logic [DATA_W-1:0] imm_val, opnd;
   logic              imm_c, opnd_c;
   logic              arith_c, arith_v;
   dp_flags_t         f_in, f_out;
   logic              unused_hi;

   always_comb begin
      op     = dp_op_e'(instr[OP_LSB +: 4]);
      s_bit  = instr[S_POS];
      i_bit  = instr[I_POS];
      rd_idx = instr[RD_LSB +: REG_W];
      rn_idx = instr[RN_LSB +: REG_W];
      f_in   = dp_flags_t'(flags_in);
   end

   assign unused_hi = ^instr[31:I_POS+1];

   dp_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
      .imm   (instr[IMM_LSB +: IMM_W]),
      .rot   (instr[ROT_LSB +: ROT_W]),
      .c_in  (f_in.c),
      .value (imm_val),
      .c_out (imm_c)
   );

   always_comb begin
      opnd   = i_bit ? imm_val : shop_val;
      opnd_c = i_bit ? imm_c   : shop_carry;
   end

   dp_arith_core #(.DATA_W(DATA_W)) u_core (
      .op      (op),
      .a       (rn_val),
      .b       (opnd),
      .c_flag  (f_in.c),
      .res     (result),
      .arith_c (arith_c),
      .arith_v (arith_v),
      .wr_en   (rd_we)
   );

   dp_flag_unit #(.DATA_W(DATA_W)) u_flags (
      .s_bit          (s_bit),
      .rd_is_pc       (rd_idx == PC_IDX),
      .mode_has_saved (mode_has_saved),
      .cls            (op_class(op)),
      .res            (result),
      .arith_c        (arith_c),
      .arith_v        (arith_v),
      .opnd_c         (opnd_c),
      .f_in           (f_in),
      .f_out          (f_out),
      .restore        (restore_req)
   );

   assign flags_out = f_out;

   always_comb begin
      if (instr[OP_LSB+3 -: 2] == 2'b10) begin
         // R8
         no_write_chk: assert (!rd_we);
      end
      if (restore_req) begin
         // R10
         restore_hold_chk: assert (flags_out == flags_in && s_bit && rd_idx == PC_IDX);
      end
      if (s_bit && !restore_req) begin
         // R11
         nz_flag_chk: assert (flags_out[3] == result[DATA_W-1] && flags_out[2] == (result == '0));
      end
   end

endmodule

// File: tb/dp_alu_unit_tb.sv
module dp_alu_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rn_val = '0;
   logic [31:0] shop_val = '0;
   logic        shop_carry = 1'b0;
   logic [3:0]  flags_in = '0;
   logic        mode_has_saved = 1'b0;
   logic [31:0] result;
   logic [3:0]  rd_idx, rn_idx;
   logic        rd_we;
   logic [3:0]  flags_out;
   logic        restore_req;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dp_alu_unit u_dut (
      .instr(instr), .rn_val(rn_val), .shop_val(shop_val), .shop_carry(shop_carry),
      .flags_in(flags_in), .mode_has_saved(mode_has_saved), .result(result),
      .rd_idx(rd_idx), .rn_idx(rn_idx), .rd_we(rd_we), .flags_out(flags_out),
      .restore_req(restore_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (instr=%h rn=%h sh=%h fl=%h)",
                  req, act, exp, instr, rn_val, shop_val, flags_in);
      end
   endtask

   // Independent reference
   task automatic model(output logic [31:0] er, output logic [3:0] ef,
                        output logic ewe, output logic ers, output bit is_logic);
      logic [31:0] b;
      logic        bc;
      int          amt;
      logic [3:0]  op;
      logic        cf, nf, zf, cc, vv;
      longint      m, s, d, sm, ss, sd;
      longint      extra;
      op = instr[24:21];
      cf = flags_in[1];
      if (instr[25]) begin
         amt = 2 * int'(instr[11:8]);
         b = (amt == 0) ? {24'd0, instr[7:0]} :
             (({24'd0, instr[7:0]} >> amt) | ({24'd0, instr[7:0]} << (32 - amt)));
         bc = (amt == 0) ? cf : b[31];
      end else begin
         b = shop_val;
         bc = shop_carry;
      end
      is_logic = 1'b0;
      cc = bc; vv = flags_in[0];
      er = '0;
      case (op)
         4'h4, 4'h5, 4'hB: begin
            extra = (op == 4'h5) ? longint'(cf) : 0;
            m = longint'(rn_val); s = longint'(b);
            d = m + s + extra;
            sd = longint'($signed(rn_val)) + longint'($signed(b)) + extra;
            er = d[31:0];
            cc = d > 64'sd4294967295;
            vv = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
         end
         4'h2, 4'h3, 4'h6, 4'h7, 4'hA: begin
            extra = ((op == 4'h6 || op == 4'h7) && !cf) ? 1 : 0;
            if (op == 4'h3 || op == 4'h7) begin
               m = longint'(b); s = longint'(rn_val);
               sm = longint'($signed(b)); ss = longint'($signed(rn_val));
            end else begin
               m = longint'(rn_val); s = longint'(b);
               sm = longint'($signed(rn_val)); ss = longint'($signed(b));
            end
            d = m - s - extra;
            sd = sm - ss - extra;
            er = d[31:0];
            cc = d >= 0;
            vv = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
         end
         default: begin
            is_logic = 1'b1;
            case (op)
               4'h0, 4'h8: er = rn_val & b;
               4'h1, 4'h9: er = rn_val ^ b;
               4'hC:       er = rn_val | b;
               4'hD:       er = b;
               4'hE:       er = rn_val & ~b;
               default:    er = ~b;
            endcase
         end
      endcase
      nf = er[31];
      zf = (er == 32'd0);
      ewe = !(op >= 4'h8 && op <= 4'hB);
      ers = instr[20] && (instr[15:12] == 4'hF) && mode_has_saved;
      if (!instr[20] || ers) ef = flags_in;
      else ef = {nf, zf, cc, vv};
   endtask

   task automatic run_vec(input bit rot_sweep);
      logic [31:0] er;
      logic [3:0]  ef;
      logic        ewe, ers;
      bit          lg;
      string       tag;
      #1;
      model(er, ef, ewe, ers, lg);
      if (rot_sweep) begin
         chk("R1 rotated constant", result, er);
         chk("R2 constant carry", {31'd0, flags_out[1]}, {31'd0, ef[1]});
         chk("R12 index fields", {24'd0, rn_idx, rd_idx}, {24'd0, instr[19:16], instr[15:12]});
         return;
      end
      if (lg) tag = instr[25] ? "R7 logical result" : "R3 register operand";
      else if (instr[24:21] == 4'h6 || instr[24:21] == 4'h7 || instr[24:21] == 4'h5)
         tag = "R6 carry-in arithmetic";
      else if (instr[24:21] == 4'h4 || instr[24:21] == 4'hB) tag = "R4 add class";
      else tag = "R5 subtract class";
      chk(tag, result, er);
      chk("R8 write enable", {31'd0, rd_we}, {31'd0, ewe});
      chk("R10 restore request", {31'd0, restore_req}, {31'd0, ers});
      if (!instr[20]) chk("R9 flags pass-through", {28'd0, flags_out}, {28'd0, ef});
      else if (ers)   chk("R10 flags held on restore", {28'd0, flags_out}, {28'd0, ef});
      else begin
         chk("R11 N/Z flags", {30'd0, flags_out[3:2]}, {30'd0, ef[3:2]});
         chk({tag, " C/V flags"}, {30'd0, flags_out[1:0]}, {30'd0, ef[1:0]});
      end
   endtask

   logic [31:0] rn_tab [8];
   logic [31:0] sh_tab [8];
   logic [7:0]  imm_tab [4];

   initial begin
      rn_tab[0] = 32'h0000_0000; sh_tab[0] = 32'h0000_0000;
      rn_tab[1] = 32'h0000_0001; sh_tab[1] = 32'hFFFF_FFFF;
      rn_tab[2] = 32'h7FFF_FFFF; sh_tab[2] = 32'h0000_0001;
      rn_tab[3] = 32'h8000_0000; sh_tab[3] = 32'h8000_0000;
      rn_tab[4] = 32'h1234_5678; sh_tab[4] = 32'h1234_5678;
      rn_tab[5] = 32'h0000_0000; sh_tab[5] = 32'h0000_0001;
      rn_tab[6] = 32'hFFFF_FFFF; sh_tab[6] = 32'hFFFF_FFFF;
      rn_tab[7] = 32'h8000_0000; sh_tab[7] = 32'h0000_0001;
      imm_tab[0] = 8'h01; imm_tab[1] = 8'h80; imm_tab[2] = 8'hFF; imm_tab[3] = 8'h5A;

      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Idle state: all-zero inputs decode as and-register, no update
      @(negedge clk);
      #1;
      chk("R8 idle write enable", {31'd0, rd_we}, 32'd1);
      chk("R9 idle flags", {28'd0, flags_out}, 32'd0);
      chk("R10 idle restore", {31'd0, restore_req}, 32'd0);
      chk("R7 idle result", result, 32'd0);

      // Constant rotation sweep with move, update on
      for (int r = 0; r < 16; r++) begin
         for (int j = 0; j < 4; j++) begin
            for (int c = 0; c < 2; c++) begin
               @(negedge clk);
               instr = {4'hE, 3'b001, 4'hD, 1'b1, 4'(j + 3), 4'(r), 4'(r), imm_tab[j]};
               rn_val = 32'hDEAD_BEEF;
               shop_val = 32'h0;
               shop_carry = ~c[0];
               flags_in = {2'b00, c[0], 1'b1};
               mode_has_saved = 1'b1;
               run_vec(1'b1);
            end
         end
      end

      // Full sweep over opcodes, update bit, operand kind, flags, operands
      for (int op = 0; op < 16; op++) begin
         for (int s = 0; s < 2; s++) begin
            for (int ib = 0; ib < 2; ib++) begin
               for (int fl = 0; fl < 16; fl++) begin
                  for (int k = 0; k < 8; k++) begin
                     @(negedge clk);
                     instr = {4'hE, 2'b00, ib[0], 4'(op), s[0], 4'(k + fl),
                              (k == 3 || k == 6) ? 4'hF : 4'(k),
                              (k == 0) ? 4'd0 : 4'(2 * k - 1),
                              imm_tab[k % 4] ^ 8'(fl)};
                     rn_val = rn_tab[k];
                     shop_val = sh_tab[k];
                     shop_carry = k[0] ^ fl[0];
                     flags_in = 4'(fl);
                     mode_has_saved = fl[1] ^ k[1];
                     run_vec(1'b0);
                  end
               end
            end
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule